// File: doc/BRIEF.md
# Framed Serial Register Slave with Start Byte

This block terminates a three-wire synchronous serial link from a host controller. The link has an active-low select, a shift clock and one data line that can turn around. Every frame opens with a header byte that names the target and the transfer direction. Every later byte in the same frame is written to that target, or read from it, until select is released. The link inputs are brought into the core clock domain and edge-detected, so the shift clock must run well below the core clock.

The register file sits inside the block: two display address registers, two general-purpose output ports, a two-part control store and a keypad read-out with a rotating group index. Display memory accesses leave the block as per-byte write and read strobes. Key states come in as a flat vector from keypad logic outside the block. For reads, the block provides the serial output value and a separate output-enable, and the chip-level pad merges the two into one bidirectional pin.

Top module: `sbyte_serial_if`

## Requirements
- R1: While select (`csN`) is high, the bit counter is cleared, a partial byte is dropped and `sdoEn` is low. The next frame starts a fresh header.
- R2: Bits are taken on rising `sclk`, most significant bit first. The header holds bits 7:6 = 11, bit 5 = memory select (1 = display memory), bit 4 = direction (1 = read) and bits 3:0 = register number.
- R3: A header whose bits 7:6 are not 11 leaves every register and strobe untouched for the rest of that frame.
- R4: Register numbers are 0 key, 1 display data, 2 X address, 3 Y address, 4 port A, 5 port B, 8 control 1 and 9 control 2. X keeps data bits 3:0 and Y keeps bits 4:0. Control 1 keeps bits 7:4 and 1:0 and reads 0 in bits 3:2. Control 2 keeps bit 0 only, and that bit drives `dispOn`. A read returns the stored value zero-extended.
- R5: Every data byte after one header is applied to the same target, so for a register the last byte wins.
- R6: Memory select = 1, or register number 1, targets display memory. Each written byte pulses `ramWrStrobe` for one cycle with the byte on `ramWrData`. Each byte read takes `ramRdData` and pulses `ramRdStrobe` for one cycle once the byte has been shifted out.
- R7: For a read header, `sdoEn` stays low through the 8th rising edge. It goes high at the falling edge that follows and stays high until select rises. `sdo` changes only on falling edges, most significant bit first.
- R8: A key read byte is {index[2:0], group}. The group for index n is `keyState[5n+4:5n]`. The index advances after each key byte is read, counts 0 to 4 and then wraps to 0.
- R9: `portAEn` and `portBEn` are low from reset until the first write to their register. From then on they stay high and the port outputs show the stored value.
- R10: Reset clears X, Y, both ports with their enables, control 2 and the key index. Control 1 keeps its value through reset.
- R11: Writes to register numbers 6, 7 and 10 to 15 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data from the pad |
| sdo | output | 1 | Serial data to the pad |
| sdoEn | output | 1 | Pad output enable |
| keyState | input | KEY_GROUPS*5 | Key states, 1 = pressed, in groups of five |
| ramRdData | input | 8 | Display memory read byte |
| ramRdStrobe | output | 1 | Display byte consumed |
| ramWrStrobe | output | 1 | Display byte write |
| ramWrData | output | 8 | Display byte to write |
| xAddr | output | X_W | X address register |
| yAddr | output | Y_W | Y address register |
| portA | output | 1 | Port A value |
| portAEn | output | 1 | Port A drive enable |
| portB | output | 8 | Port B value |
| portBEn | output | 1 | Port B drive enable |
| ctrl1 | output | 8 | Control 1 (bits 3:2 read 0) |
| dispOn | output | 1 | Control 2 display-on bit |

## Verification
A reference model in the bench tracks every register output and is compared with the design on each core clock between frames. Single-byte writes with all bits set separate the field masks of each register. Multi-byte write frames check that one header serves every byte, and that both ways of selecting display memory are decoded. Headers with a bad prefix, and frames cut short mid-byte, show whether stray bits can reach a register. Six-byte key reads expose the index wrap. Memory reads check the turn-around edge and the strobe count. A reset in the middle of the run separates the control store, which keeps its value, from the registers that are cleared.

// File: rtl/sbyte_pkg.sv
package sbyte_pkg;
  localparam int BYTE_W = 8;
  localparam int KEY_GW = 5;

  typedef enum logic [1:0] {PH_HDR, PH_DATA, PH_DROP} phase_e;

  localparam logic [3:0] REG_KEY  = 4'd0;
  localparam logic [3:0] REG_DISP = 4'd1;
  localparam logic [3:0] REG_XADR = 4'd2;
  localparam logic [3:0] REG_YADR = 4'd3;
  localparam logic [3:0] REG_PTA  = 4'd4;
  localparam logic [3:0] REG_PTB  = 4'd5;
  localparam logic [3:0] REG_CTL1 = 4'd8;
  localparam logic [3:0] REG_CTL2 = 4'd9;

  typedef struct packed {
    logic       shiftIn;
    logic       wrByte;
    logic       rdAdvance;
    logic       loadTx;
    logic       shiftTx;
    logic       toRam;
    logic [3:0] regNum;
  } strobes_t;
endpackage

// File: rtl/sbyte_sync.sv
module sbyte_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csNIn,
  input  logic sclkIn,
  input  logic sdiIn,
  output logic selected,
  output logic sclkRise,
  output logic sclkFall,
  output logic sdiS
);
  logic [STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      sclkLast <= 1'b0;
    end else begin
      csPipe   <= {csPipe[STAGES-2:0], csNIn};
      sclkPipe <= {sclkPipe[STAGES-2:0], sclkIn};
      sdiPipe  <= {sdiPipe[STAGES-2:0], sdiIn};
      sclkLast <= sclkPipe[STAGES-1];
    end
  end

  assign selected = ~csPipe[STAGES-1];
  assign sclkRise = sclkPipe[STAGES-1] & ~sclkLast;
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkLast;
  assign sdiS     = sdiPipe[STAGES-1];
endmodule

// File: rtl/sbyte_ctrl.sv
module sbyte_ctrl import sbyte_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selected,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic [BYTE_W-1:0] rxByte,
  output strobes_t          strb,
  output logic              sdoEn
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0] bitCnt;
  phase_e phase;
  logic isRead, toRam, needLoad;
  logic [3:0] regNum;
  logic byteEnd, prefixOk;

  assign byteEnd  = selected && sclkRise && (bitCnt == CNT_W'(BYTE_W - 1));
  assign prefixOk = (rxByte[7:6] == 2'b11);

  always_comb begin
    strb.shiftIn   = selected && sclkRise;
    strb.wrByte    = byteEnd && (phase == PH_DATA) && !isRead;
    strb.rdAdvance = byteEnd && (phase == PH_DATA) && isRead;
    strb.loadTx    = selected && sclkFall && needLoad;
    strb.shiftTx   = selected && sclkFall && !needLoad && sdoEn;
    strb.toRam     = toRam;
    strb.regNum    = regNum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      phase    <= PH_HDR;
      isRead   <= 1'b0;
      toRam    <= 1'b0;
      regNum   <= '0;
      needLoad <= 1'b0;
      sdoEn    <= 1'b0;
    end else if (!selected) begin
      bitCnt   <= '0;
      phase    <= PH_HDR;
      isRead   <= 1'b0;
      needLoad <= 1'b0;
      sdoEn    <= 1'b0;
    end else begin
      if (sclkRise) begin
        bitCnt <= bitCnt + 1'b1;
        if (byteEnd) begin
          if (phase == PH_HDR) begin
            if (prefixOk) begin
              phase    <= PH_DATA;
              isRead   <= rxByte[4];
              toRam    <= rxByte[5] || (rxByte[3:0] == REG_DISP);
              regNum   <= rxByte[3:0];
              needLoad <= rxByte[4];
            end else begin
              phase <= PH_DROP;
            end
          end else if (phase == PH_DATA && isRead) begin
            needLoad <= 1'b1;
          end
        end
      end
      if (sclkFall && needLoad) begin
        needLoad <= 1'b0;
        sdoEn    <= 1'b1;
      end
    end
  end

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !selected |=> !sdoEn); // R1
  AST_DESEL_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !selected |=> (bitCnt == '0)); // R1
  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> $past(sclkFall)); // R7
  AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !strb.wrByte); // R7
  AST_DROP_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DROP) |-> !(strb.wrByte || strb.rdAdvance)); // R3
endmodule

// File: rtl/sbyte_datapath.sv
module sbyte_datapath import sbyte_pkg::*; #(
  parameter int KEY_GROUPS = 5,
  parameter int X_W        = 4,
  parameter int Y_W        = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobes_t                     strb,
  input  logic                         sdiS,
  input  logic [KEY_GROUPS*KEY_GW-1:0] keyState,
  input  logic [BYTE_W-1:0]            ramRdData,
  output logic [BYTE_W-1:0]            rxByte,
  output logic                         sdo,
  output logic                         ramWrStrobe,
  output logic [BYTE_W-1:0]            ramWrData,
  output logic                         ramRdStrobe,
  output logic [X_W-1:0]               xAddr,
  output logic [Y_W-1:0]               yAddr,
  output logic                         portA,
  output logic                         portAEn,
  output logic [BYTE_W-1:0]            portB,
  output logic                         portBEn,
  output logic [BYTE_W-1:0]            ctrl1,
  output logic                         dispOn
);
  localparam int KCNT_W = BYTE_W - KEY_GW;

  logic [BYTE_W-1:0] shReg, txReg, rdMux;
  logic [KCNT_W-1:0] keyCnt;
  logic [KEY_GW-1:0] keyGroups [KEY_GROUPS];
  logic [KEY_GW-1:0] keyGrp;
  logic keyAdv, regWr;

  for (genvar g = 0; g < KEY_GROUPS; g++) begin : g_keyGrp
    assign keyGroups[g] = keyState[g*KEY_GW +: KEY_GW];
  end

  always_comb begin
    keyGrp = '0;
    for (int g = 0; g < KEY_GROUPS; g++)
      if (keyCnt == KCNT_W'(g)) keyGrp = keyGroups[g];
  end

  assign rxByte      = {shReg[BYTE_W-2:0], sdiS};
  assign sdo         = txReg[BYTE_W-1];
  assign regWr       = strb.wrByte && !strb.toRam;
  assign keyAdv      = strb.rdAdvance && !strb.toRam && (strb.regNum == REG_KEY);
  assign ramWrStrobe = strb.wrByte && strb.toRam;
  assign ramWrData   = rxByte;
  assign ramRdStrobe = strb.rdAdvance && strb.toRam;

  always_comb begin
    rdMux = '0;
    if (strb.toRam) begin
      rdMux = ramRdData;
    end else begin
      case (strb.regNum)
        REG_KEY:  rdMux = {keyCnt, keyGrp};
        REG_XADR: rdMux = BYTE_W'(xAddr);
        REG_YADR: rdMux = BYTE_W'(yAddr);
        REG_PTA:  rdMux = BYTE_W'(portA);
        REG_PTB:  rdMux = portB;
        REG_CTL1: rdMux = ctrl1;
        REG_CTL2: rdMux = BYTE_W'(dispOn);
        default:  rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      txReg   <= '0;
      keyCnt  <= '0;
      xAddr   <= '0;
      yAddr   <= '0;
      portA   <= 1'b0;
      portAEn <= 1'b0;
      portB   <= '0;
      portBEn <= 1'b0;
      dispOn  <= 1'b0;
    end else begin
      if (strb.shiftIn) shReg <= rxByte;
      if (strb.loadTx) txReg <= rdMux;
      else if (strb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b0};
      if (keyAdv)
        keyCnt <= (keyCnt == KCNT_W'(KEY_GROUPS - 1)) ? '0 : keyCnt + 1'b1;
      if (regWr) begin
        case (strb.regNum)
          REG_XADR: xAddr <= rxByte[X_W-1:0];
          REG_YADR: yAddr <= rxByte[Y_W-1:0];
          REG_PTA: begin
            portA   <= rxByte[0];
            portAEn <= 1'b1;
          end
          REG_PTB: begin
            portB   <= rxByte;
            portBEn <= 1'b1;
          end
          REG_CTL2: dispOn <= rxByte[0];
          default: ;
        endcase
      end
    end
  end

  // Control 1 deliberately has no reset term: it survives reset.
  always_ff @(posedge clk) begin
    if (regWr && strb.regNum == REG_CTL1)
      ctrl1 <= {rxByte[7:4], 2'b00, rxByte[1:0]};
  end

  AST_KEY_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    keyCnt < KCNT_W'(KEY_GROUPS)); // R8
  AST_KEY_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (keyAdv && keyCnt == KCNT_W'(KEY_GROUPS - 1)) |=> (keyCnt == '0)); // R8
  AST_PORTA_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    portAEn |=> portAEn); // R9
  AST_PORTB_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    portBEn |=> portBEn); // R9
  AST_RAM_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWrStrobe && ramRdStrobe)); // R6
endmodule

// File: rtl/sbyte_serial_if.sv
module sbyte_serial_if import sbyte_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int KEY_GROUPS  = 5,
  parameter int X_W         = 4,
  parameter int Y_W         = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         csN,
  input  logic                         sclk,
  input  logic                         sdi,
  output logic                         sdo,
  output logic                         sdoEn,
  input  logic [KEY_GROUPS*KEY_GW-1:0] keyState,
  input  logic [BYTE_W-1:0]            ramRdData,
  output logic                         ramRdStrobe,
  output logic                         ramWrStrobe,
  output logic [BYTE_W-1:0]            ramWrData,
  output logic [X_W-1:0]               xAddr,
  output logic [Y_W-1:0]               yAddr,
  output logic                         portA,
  output logic                         portAEn,
  output logic [BYTE_W-1:0]            portB,
  output logic                         portBEn,
  output logic [BYTE_W-1:0]            ctrl1,
  output logic                         dispOn
);
  logic selected, sclkRise, sclkFall, sdiS;
  logic [BYTE_W-1:0] rxByte;
  strobes_t strb;

  sbyte_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .csNIn(csN), .sclkIn(sclk), .sdiIn(sdi),
    .selected(selected), .sclkRise(sclkRise), .sclkFall(sclkFall), .sdiS(sdiS)
  );

  sbyte_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selected(selected), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .rxByte(rxByte), .strb(strb), .sdoEn(sdoEn)
  );

  sbyte_datapath #(.KEY_GROUPS(KEY_GROUPS), .X_W(X_W), .Y_W(Y_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiS(sdiS), .keyState(keyState),
    .ramRdData(ramRdData), .rxByte(rxByte), .sdo(sdo),
    .ramWrStrobe(ramWrStrobe), .ramWrData(ramWrData), .ramRdStrobe(ramRdStrobe),
    .xAddr(xAddr), .yAddr(yAddr), .portA(portA), .portAEn(portAEn),
    .portB(portB), .portBEn(portBEn), .ctrl1(ctrl1), .dispOn(dispOn)
  );
endmodule

// File: tb/sbyte_serial_if_test.sv
module sbyte_serial_if_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, csN, sclk, sdi;
  logic sdo, sdoEn, ramRdStrobe, ramWrStrobe;
  logic [24:0] keyState;
  logic [7:0] ramRdData, ramWrData, portB, ctrl1;
  logic [3:0] xAddr;
  logic [4:0] yAddr;
  logic portA, portAEn, portBEn, dispOn;

  int ramRdIdx = 0;
  assign ramRdData = 8'h80 + 8'(ramRdIdx);

  sbyte_serial_if uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdoEn(sdoEn), .keyState(keyState), .ramRdData(ramRdData),
    .ramRdStrobe(ramRdStrobe), .ramWrStrobe(ramWrStrobe), .ramWrData(ramWrData),
    .xAddr(xAddr), .yAddr(yAddr), .portA(portA), .portAEn(portAEn),
    .portB(portB), .portBEn(portBEn), .ctrl1(ctrl1), .dispOn(dispOn)
  );

  int checks = 0, errors = 0;
  logic [3:0] mX; logic [4:0] mY; logic mPA, mPAEn, mPBEn, mDisp, mC1Known;
  logic [7:0] mPB, mC1;
  bit quiet = 0;
  logic [7:0] ramWrQ[$];
  logic [7:0] rdBuf[8];
  logic [4:0] grp[5];
  logic oeLastFall, oeHdr, oeDataOk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Every-clock comparison against the behavioural model between frames (R4, R9, R10, R1)
  always @(negedge clk) begin
    if (ramWrStrobe) ramWrQ.push_back(ramWrData);
    if (ramRdStrobe) ramRdIdx++;
    if (quiet && rstN) begin
      checks++;
      if ({xAddr, yAddr, portA, portAEn, portB, portBEn, dispOn, sdoEn} !==
          {mX, mY, mPA, mPAEn, mPB, mPBEn, mDisp, 1'b0} ||
          (mC1Known && ctrl1 !== mC1)) begin
        errors++;
        $display("FAIL R4 R9 R10 model: got x%h y%h a%b%b b%h%b c%h d%b oe%b expected x%h y%h a%b%b b%h%b c%h d%b oe0",
          xAddr, yAddr, portA, portAEn, portB, portBEn, ctrl1, dispOn, sdoEn,
          mX, mY, mPA, mPAEn, mPB, mPBEn, mC1, mDisp);
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, input bit dataRead, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = sdo;
      if (dataRead && sdoEn !== 1'b1) oeDataOk = 1'b0;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      if (i == 0) oeLastFall = sdoEn;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic beginF();
    quiet = 0;
    csN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic endF();
    repeat (6) @(negedge clk);
    csN = 1'b1;
    repeat (10) @(negedge clk);
    quiet = 1;
  endtask

  task automatic model(input logic [3:0] num, input logic [7:0] d);
    case (num)
      4'd2: mX = d[3:0];
      4'd3: mY = d[4:0];
      4'd4: begin mPA = d[0]; mPAEn = 1'b1; end
      4'd5: begin mPB = d; mPBEn = 1'b1; end
      4'd8: begin mC1 = d & 8'hF3; mC1Known = 1'b1; end
      4'd9: mDisp = d[0];
      default: ;
    endcase
  endtask

  task automatic writeReg(input logic [3:0] num, input logic [7:0] d);
    logic [7:0] junk;
    beginF();
    xfer({4'b1100, num}, 1'b0, junk);
    xfer(d, 1'b0, junk);
    model(num, d);
    endF();
  endtask

  task automatic readRegs(input logic [7:0] hdr, input int n);
    logic [7:0] junk;
    beginF();
    oeDataOk = 1'b1;
    xfer(hdr, 1'b0, junk);
    oeHdr = oeLastFall;
    for (int k = 0; k < n; k++) xfer(8'h00, 1'b1, rdBuf[k]);
    endF();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] junk;
    int base;
    grp[0] = 5'h01; grp[1] = 5'h1F; grp[2] = 5'h0A; grp[3] = 5'h15; grp[4] = 5'h10;
    keyState = {grp[4], grp[3], grp[2], grp[1], grp[0]};
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0;
    mX = 0; mY = 0; mPA = 0; mPAEn = 0; mPB = 0; mPBEn = 0; mDisp = 0;
    mC1 = 0; mC1Known = 0;
    repeat (5) @(negedge clk);
    check("R10 reset sdoEn", sdoEn, 0);
    check("R9 reset port enables", {portAEn, portBEn}, 0);
    check("R10 reset x/y/disp", {xAddr, yAddr, dispOn}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    quiet = 1;

    // R2 R4: address masks and readback
    writeReg(4'd2, 8'h5A);
    check("R4 X keeps low nibble", xAddr, 4'hA);
    readRegs(8'hD2, 1);
    check("R4 X readback", rdBuf[0], 8'h0A);
    check("R7 no drive before falling edge", oeHdr, 0);
    check("R7 drive through data bits", oeDataOk, 1);
    writeReg(4'd3, 8'hFF);
    check("R4 Y keeps five bits", yAddr, 5'h1F);
    writeReg(4'd8, 8'hFF);
    readRegs(8'hD8, 1);
    check("R4 control 1 readback", rdBuf[0], 8'hF3);
    writeReg(4'd9, 8'hFD);
    check("R4 dispOn", dispOn, 1);
    readRegs(8'hD9, 1);
    check("R4 control 2 readback", rdBuf[0], 8'h01);

    // R9 ports
    check("R9 port A undriven before write", portAEn, 0);
    writeReg(4'd4, 8'hFF);
    check("R9 port A driven", {portAEn, portA}, 2'b11);
    writeReg(4'd5, 8'hA5);
    check("R9 port B driven", {portBEn, portB}, {1'b1, 8'hA5});

    // R3 bad prefix
    beginF(); xfer(8'h82, 1'b0, junk); xfer(8'h07, 1'b0, junk); endF();
    beginF(); xfer(8'h42, 1'b0, junk); xfer(8'h03, 1'b0, junk); endF();
    check("R3 bad prefix ignored", xAddr, 4'hA);

    // R1 partial byte dropped
    beginF();
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b1; repeat (8) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    endF();
    writeReg(4'd2, 8'h03);
    check("R1 frame realigned after partial byte", xAddr, 4'h3);

    // R5 several bytes after one header
    beginF();
    xfer(8'hC2, 1'b0, junk); xfer(8'h01, 1'b0, junk);
    xfer(8'h02, 1'b0, junk); xfer(8'h07, 1'b0, junk);
    mX = 4'h7;
    endF();
    check("R5 last byte wins", xAddr, 4'h7);

    // R6 display writes, both selection forms
    ramWrQ.delete();
    beginF();
    xfer(8'hE0, 1'b0, junk); xfer(8'h11, 1'b0, junk);
    xfer(8'h22, 1'b0, junk); xfer(8'h33, 1'b0, junk);
    endF();
    beginF(); xfer(8'hC1, 1'b0, junk); xfer(8'h44, 1'b0, junk); endF();
    check("R6 write strobe count", ramWrQ.size(), 4);
    if (ramWrQ.size() == 4)
      check("R5 R6 write bytes", {ramWrQ[0], ramWrQ[1], ramWrQ[2], ramWrQ[3]}, 32'h11223344);

    // R6 R7 display reads
    base = ramRdIdx;
    readRegs(8'hF0, 3);
    for (int k = 0; k < 3; k++)
      check("R6 R7 display read byte", rdBuf[k], 8'h80 + 8'(base + k));
    check("R6 read strobe count", ramRdIdx - base, 3);
    check("R7 drive window", {oeHdr, oeDataOk}, 2'b01);
    check("R1 released after frame", sdoEn, 0);

    // R8 key groups with wrap
    readRegs(8'hD0, 6);
    for (int k = 0; k < 6; k++)
      check("R8 key byte", rdBuf[k], {3'(k % 5), grp[k % 5]});

    // R11 unused numbers
    writeReg(4'd6, 8'hFF);
    readRegs(8'hD6, 1);
    check("R11 unused reads zero", rdBuf[0], 8'h00);
    readRegs(8'hDF, 1);
    check("R11 unused 15 reads zero", rdBuf[0], 8'h00);

    // R10 reset keeps control 1, clears the rest
    writeReg(4'd8, 8'hA2);
    quiet = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset clears ports", {portAEn, portBEn, portA, portB}, 0);
    rstN = 1'b1;
    mX = 0; mY = 0; mPA = 0; mPAEn = 0; mPB = 0; mPBEn = 0; mDisp = 0;
    repeat (3) @(negedge clk);
    quiet = 1;
    readRegs(8'hD8, 1);
    check("R10 control 1 kept", rdBuf[0], 8'hA2);
    readRegs(8'hD0, 1);
    check("R10 R8 key index cleared", rdBuf[0], {3'd0, grp[0]});

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule